// File: doc/BRIEF.md
# Stereo serial audio to twin right-justified word streams

This block takes a standard I2S stereo stream and splits it into two separate mono serial streams, one per channel, each formatted for a right-justified converter input. Every output word is 32 bit periods long in both 16-bit and 24-bit modes, so the delay through the block is the same for either sample width. Each output stream has its own data line, its own bit clock and its own word latch.

The input frame is 64 bit clocks long: 32 with word select low, which carry the left channel, and 32 with it high, which carry the right channel. Each sample is sent MSB first, starting one bit period after the word select edge. The block delays the serial bits with a shift register clocked by the input bit clock. The left channel is taken from a deeper tap, so that both channels line up. During the right-channel half of each input frame, both output bit clocks run for 32 periods. For the other 32 periods they are held low. In 16-bit mode the eight bit periods after the sample are filled with zeros.

Top module: `i2s_dual_rj`

## Requirements
- R1: Between two rising edges of an output word latch, the output bit clock produces exactly 32 rising edges.
- R2: The first 8 bits of every output word are 0, whatever the serial input carries at those times.
- R3: With `wide_sel` = 1 (24-bit mode), output bits 9 to 32 carry the 24-bit sample MSB first, and the sample's LSB is the last bit before the word latch rises.
- R4: With `wide_sel` = 0 (16-bit mode), output bits 9 to 24 carry the 16-bit sample MSB first and bits 25 to 32 are 0, even when the input drives ones in the unused bit slots.
- R5: The left and right output bit clocks and word latches toggle on the same edges, and the two words of one input frame come out at the same time.
- R6: Each output bit clock is held low for 32 of every 64 input bit periods, including bit periods 1 to 32 after the word select fall. The output data is 0 whenever its bit clock is held.
- R7: Each word latch is low while its bit clock runs and rises on the input bit clock falling edge that follows the word's last bit. At that point the bit clock is already stopped.
- R8: `wide_sel` is sampled only on the first rising input bit clock edge after word select falls. A change in the middle of a frame first affects the next frame.
- R9: During reset, and after reset until the first word select fall, all six outputs stay at 0.
- R10: The sample sent while word select is low comes out on the `l_` outputs. The sample sent while word select is high comes out on the `r_` outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | I2S bit clock; the input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws | input | 1 | I2S word select; low = left, high = right |
| sd | input | 1 | I2S serial data |
| wide_sel | input | 1 | Sample width select: 1 = 24-bit, 0 = 16-bit |
| l_bck | output | 1 | Left stream gated bit clock |
| l_dat | output | 1 | Left stream serial data; changes on falling edges |
| l_lat | output | 1 | Left stream word latch |
| r_bck | output | 1 | Right stream gated bit clock |
| r_dat | output | 1 | Right stream serial data; changes on falling edges |
| r_lat | output | 1 | Right stream word latch |

## Verification
The bound checker watches, on every cycle, the framing rules that hold for any sample values. These are the 32-clock word length, the latch that stays low while the clock runs, the data that stays low while the clock is held, and the lock-step timing of the two lanes. The actual payload can only be shown by the bench's scenarios, which rebuild each word from the output pins. They cover the bit order, the zero dummy field, the zero tail in 16-bit mode against input slots driven with ones, the mapping of channels to outputs, and the mode latched at the frame boundary when `wide_sel` changes in the middle of a frame.

// File: rtl/i2s_rj_pkg.sv
package i2s_rj_pkg;

   typedef enum logic {
      WL_NARROW = 1'b0,
      WL_WIDE   = 1'b1
   } wlen_e;

   // number of payload bits carried for a given width mode
   function automatic int payload_bits(input wlen_e mode, input int narrow, input int wide);
      return (mode == WL_WIDE) ? wide : narrow;
   endfunction

endpackage

// File: rtl/rj_frame_tracker.sv
module rj_frame_tracker
   import i2s_rj_pkg::*;
#(
   parameter int SLOT_BITS = 32,
   localparam int FRAME_BITS = 2 * SLOT_BITS,
   localparam int CW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ws,
   input  logic          wide_sel,
   output logic [CW-1:0] pos,
   output wlen_e         mode_q,
   output logic          locked
);

   localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

   logic ws_prev;
   logic seen;
   logic frame_start;

   assign frame_start = seen & ws_prev & ~ws;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_prev <= 1'b1;
         seen    <= 1'b0;
         pos     <= '0;
         mode_q  <= WL_WIDE;
         locked  <= 1'b0;
      end else begin
         seen    <= 1'b1;
         ws_prev <= ws;
         if (frame_start) begin
            pos    <= '0;
            mode_q <= wlen_e'(wide_sel);
            locked <= 1'b1;
         end else if (pos == LAST_POS) begin
            pos <= '0;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rj_tap_chain.sv
module rj_tap_chain #(
   parameter int DEPTH = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [DEPTH-1:0] taps
);

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic src;
      if (s == 0) begin : g_head
         assign src = din;
      end else begin : g_body
         assign src = taps[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) taps[s] <= 1'b0;
         else        taps[s] <= src;
      end
   end

endmodule

// File: rtl/rj_out_lane.sv
module rj_out_lane
   import i2s_rj_pkg::*;
#(
   parameter int SLOT_BITS   = 32,
   parameter int PAD_BITS    = 8,
   parameter int WIDE_BITS   = 24,
   parameter int NARROW_BITS = 16,
   localparam int CW = $clog2(2 * SLOT_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] pos,
   input  wlen_e         mode_q,
   input  logic          locked,
   input  logic          tap_bit,
   output logic          o_bck,
   output logic          o_dat,
   output logic          o_lat
);

   logic          in_window;
   logic [CW-1:0] rel;
   logic [CW-1:0] data_end;
   logic          in_payload;
   logic          gate_q;

   assign in_window  = (pos >= CW'(SLOT_BITS));
   assign rel        = pos - CW'(SLOT_BITS);
   assign data_end   = CW'(PAD_BITS + payload_bits(mode_q, NARROW_BITS, WIDE_BITS));
   assign in_payload = in_window && (rel >= CW'(PAD_BITS)) && (rel < data_end);

   // launch on the falling edge so the gate never changes while clk is high
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         o_dat  <= 1'b0;
         o_lat  <= 1'b0;
      end else begin
         gate_q <= locked & in_window;
         o_dat  <= locked & in_payload & tap_bit;
         o_lat  <= locked & ~in_window;
      end
   end

   assign o_bck = clk & gate_q;

endmodule

// File: rtl/i2s_dual_rj.sv
module i2s_dual_rj
   import i2s_rj_pkg::*;
#(
   parameter int SLOT_BITS   = 32,
   parameter int PAD_BITS    = 8,
   parameter int WIDE_BITS   = 24,
   parameter int NARROW_BITS = 16
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic ws,
   input  logic sd,
   input  logic wide_sel,
   output logic l_bck,
   output logic l_dat,
   output logic l_lat,
   output logic r_bck,
   output logic r_dat,
   output logic r_lat
);

   localparam int CW        = $clog2(2 * SLOT_BITS);
   localparam int RIGHT_TAP = PAD_BITS - 1;
   localparam int LEFT_TAP  = RIGHT_TAP + SLOT_BITS;
   localparam int DEPTH     = LEFT_TAP + 1;
   localparam int LANES     = 2;

   if (PAD_BITS + WIDE_BITS != SLOT_BITS) begin : g_bad_fill
      $error("pad plus wide sample must fill one slot exactly");
   end
   if (NARROW_BITS >= WIDE_BITS || NARROW_BITS < 1) begin : g_bad_narrow
      $error("narrow width must be positive and below the wide width");
   end
   if (PAD_BITS < 1) begin : g_bad_pad
      $error("pad field needs at least one bit");
   end

   logic [CW-1:0]    pos;
   wlen_e            mode_q;
   logic             locked;
   logic [DEPTH-1:0] taps;
   logic [LANES-1:0] bck_v, dat_v, lat_v;

   rj_frame_tracker #(.SLOT_BITS(SLOT_BITS)) i_track (
      .clk      (bclk),
      .rst_n    (rst_n),
      .ws       (ws),
      .wide_sel (wide_sel),
      .pos      (pos),
      .mode_q   (mode_q),
      .locked   (locked)
   );

   rj_tap_chain #(.DEPTH(DEPTH)) i_chain (
      .clk   (bclk),
      .rst_n (rst_n),
      .din   (sd),
      .taps  (taps)
   );

   // lane 0 = left (deep tap), lane 1 = right (shallow tap)
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int TAP = (g == 0) ? LEFT_TAP : RIGHT_TAP;
      rj_out_lane #(
         .SLOT_BITS   (SLOT_BITS),
         .PAD_BITS    (PAD_BITS),
         .WIDE_BITS   (WIDE_BITS),
         .NARROW_BITS (NARROW_BITS)
      ) i_lane (
         .clk     (bclk),
         .rst_n   (rst_n),
         .pos     (pos),
         .mode_q  (mode_q),
         .locked  (locked),
         .tap_bit (taps[TAP]),
         .o_bck   (bck_v[g]),
         .o_dat   (dat_v[g]),
         .o_lat   (lat_v[g])
      );
   end

   assign l_bck = bck_v[0];
   assign l_dat = dat_v[0];
   assign l_lat = lat_v[0];
   assign r_bck = bck_v[1];
   assign r_dat = dat_v[1];
   assign r_lat = lat_v[1];

endmodule

// File: rtl/rj_checker.sv
module rj_checker #(
   parameter int OUT_BITS = 32
) (
   input logic bclk,
   input logic rst_n,
   input logic l_bck,
   input logic l_dat,
   input logic l_lat,
   input logic r_bck,
   input logic r_dat,
   input logic r_lat
);

   localparam int PW = $clog2(OUT_BITS) + 2;

   logic [PW-1:0] pulses;

   // counts left clock pulses since the latch last went low
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n)                pulses <= '0;
      else if ($sampled(l_lat))  pulses <= '0;
      else if ($sampled(l_bck))  pulses <= pulses + 1'b1;
   end

   AST_WORD_LENGTH: assert property (@(negedge bclk) disable iff (!rst_n)
      ($rose(l_lat) && pulses != '0) |-> (pulses == PW'(OUT_BITS))); // R1

   AST_LATCH_LOW_WHILE_CLOCKING: assert property (@(negedge bclk) disable iff (!rst_n)
      (l_bck || r_bck) |-> (!l_lat && !r_lat)); // R7

   AST_CLOCK_STOPPED_AT_LATCH: assert property (@(negedge bclk) disable iff (!rst_n)
      $rose(l_lat) |-> !l_bck); // R7

   AST_IDLE_DATA_LOW: assert property (@(negedge bclk) disable iff (!rst_n)
      (!l_bck |-> !l_dat) and (!r_bck |-> !r_dat)); // R6

   AST_LANES_ALIGNED: assert property (@(negedge bclk) disable iff (!rst_n)
      (l_bck == r_bck) && (l_lat == r_lat)); // R5

endmodule

bind i2s_dual_rj rj_checker #(.OUT_BITS(SLOT_BITS)) i_rj_checker (
   .bclk  (bclk),
   .rst_n (rst_n),
   .l_bck (l_bck),
   .l_dat (l_dat),
   .l_lat (l_lat),
   .r_bck (r_bck),
   .r_dat (r_dat),
   .r_lat (r_lat)
);

// File: tb/test_i2s_dual_rj.sv
module test_i2s_dual_rj;

   logic bclk = 1'b0;
   logic rst_n = 1'b0;
   logic ws = 1'b1;
   logic sd = 1'b0;
   logic wide_sel = 1'b1;
   logic l_bck, l_dat, l_lat, r_bck, r_dat, r_lat;

   int nchk = 0;
   int nfail = 0;

   always #5 bclk = ~bclk;

   i2s_dual_rj i_i2s_dual_rj (
      .bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd), .wide_sel(wide_sel),
      .l_bck(l_bck), .l_dat(l_dat), .l_lat(l_lat),
      .r_bck(r_bck), .r_dat(r_dat), .r_lat(r_lat)
   );

   typedef struct {
      logic [31:0] lw;
      logic [31:0] rw;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] lact_q[$];
   logic [31:0] ract_q[$];
   int          lcnt_q[$];
   int          rcnt_q[$];

   logic [31:0] lsh = '0, rsh = '0;
   int          lbits = 0, rbits = 0;

   // rebuild words from the output pins
   always @(posedge l_bck) begin lsh = {lsh[30:0], l_dat}; lbits++; end
   always @(posedge r_bck) begin rsh = {rsh[30:0], r_dat}; rbits++; end
   always @(posedge l_lat) begin
      if (lbits != 0) begin lact_q.push_back(lsh); lcnt_q.push_back(lbits); end
      lbits = 0;
   end
   always @(posedge r_lat) begin
      if (rbits != 0) begin ract_q.push_back(rsh); rcnt_q.push_back(rbits); end
      rbits = 0;
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] fmt_word(input logic [23:0] s, input bit wide);
      if (wide) return {8'h00, s};
      return {8'h00, s[15:0], 8'h00};
   endfunction

   // one 64-bit-clock stereo frame; unused slots are driven with ones
   task automatic send_frame(input logic [23:0] ls, input logic [23:0] rs, input bit wide,
                             input string tag, input int sel_at, input bit new_sel, input bit probe);
      int w = wide ? 24 : 16;
      exp_t e;
      e.lw = fmt_word(ls, wide);
      e.rw = fmt_word(rs, wide);
      e.tag = tag;
      exp_q.push_back(e);
      for (int p = 0; p < 64; p++) begin
         @(negedge bclk);
         ws = (p >= 32);
         if (p >= 1 && p <= w)              sd = ls[w-1-(p-1)];
         else if (p >= 33 && p <= 32 + w)   sd = rs[w-1-(p-33)];
         else                               sd = 1'b1;
         if (p == sel_at) wide_sel = new_sel;
         if (probe && p == 10) begin
            @(posedge bclk); #3;
            chk(l_bck == 1'b0 && r_bck == 1'b0, "R6 clock held in left slot", {30'd0, l_bck, r_bck}, 32'd0);
            chk(l_dat == 1'b0 && r_dat == 1'b0, "R6 data low while held", {30'd0, l_dat, r_dat}, 32'd0);
            chk(l_lat == 1'b1 && r_lat == 1'b1, "R7 latch high while held", {30'd0, l_lat, r_lat}, 32'd3);
         end
         if (probe && p == 45) begin
            @(posedge bclk); #3;
            chk(l_bck == 1'b1 && r_bck == 1'b1, "R5 R6 clocks running together", {30'd0, l_bck, r_bck}, 32'd3);
            chk(l_lat == 1'b0 && r_lat == 1'b0, "R7 latch low while clocking", {30'd0, l_lat, r_lat}, 32'd0);
         end
      end
   endtask

   task automatic drain();
      @(posedge bclk); #1;
      while (exp_q.size() > 0 && lact_q.size() > 0 && ract_q.size() > 0) begin
         exp_t e = exp_q.pop_front();
         logic [31:0] lw = lact_q.pop_front();
         logic [31:0] rw = ract_q.pop_front();
         int lc = lcnt_q.pop_front();
         int rc = rcnt_q.pop_front();
         chk(lw == e.lw, {e.tag, " left word"}, lw, e.lw);
         chk(rw == e.rw, {e.tag, " R5 right word"}, rw, e.rw);
         chk(lc == 32, "R1 left clock count", 32'(lc), 32'd32);
         chk(rc == 32, "R1 right clock count", 32'(rc), 32'd32);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ws = 1'b1; sd = 1'b0; wide_sel = 1'b1;
      repeat (4) @(negedge bclk);
      @(posedge bclk); #3;
      chk({l_bck, l_dat, l_lat, r_bck, r_dat, r_lat} == 6'b0, "R9 outputs in reset",
          {26'd0, l_bck, l_dat, l_lat, r_bck, r_dat, r_lat}, 32'd0);
      @(negedge bclk); rst_n = 1'b1; sd = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(posedge bclk); #3;
         chk({l_bck, l_dat, l_lat, r_bck, r_dat, r_lat} == 6'b0, "R9 outputs before first frame",
             {26'd0, l_bck, l_dat, l_lat, r_bck, r_dat, r_lat}, 32'd0);
      end
      chk(lact_q.size() == 0, "R9 no word before lock", 32'(lact_q.size()), 32'd0);
   endtask

   task automatic t_wide();
      send_frame(24'hA5C3F1, 24'h1E2D3C, 1, "R3 R10 R2", -1, 0, 0);
      send_frame(24'h123456, 24'hFEDCBA, 1, "R3 R10", -1, 0, 0);
      send_frame(24'h800001, 24'h7FFFFE, 1, "R3 R2", -1, 0, 1);
      drain();
   endtask

   task automatic t_narrow();
      send_frame(24'h00BEEF, 24'h00CAFE, 0, "R4 R10", 0, 0, 0);
      send_frame(24'h00FFFF, 24'h000001, 0, "R4 R2", -1, 0, 0);
      send_frame(24'h008000, 24'h007FFF, 0, "R4", -1, 0, 1);
      drain();
   endtask

   task automatic t_mode_switch();
      send_frame(24'h00A1B2, 24'h00C3D4, 0, "R8 narrow kept mid frame", 10, 1, 0);
      send_frame(24'h5A5A5A, 24'hC0FFEE, 1, "R8 wide next frame", -1, 0, 0);
      send_frame(24'h0F0F0F, 24'hF0F0F0, 1, "R8 wide kept mid frame", 40, 0, 0);
      send_frame(24'h001234, 24'h00ABCD, 0, "R8 narrow next frame", -1, 0, 0);
      drain();
   endtask

   task automatic t_extremes();
      send_frame(24'hFFFFFF, 24'h000001, 1, "R3 all ones", 0, 1, 0);
      send_frame(24'h000000, 24'hFFFFFF, 1, "R2 R3 zeros and ones", -1, 0, 0);
      send_frame(24'h00FFFF, 24'h00FFFF, 0, "R4 tail zero under junk", 0, 0, 0);
      send_frame(24'h000000, 24'h000000, 0, "R4 R2 silent", -1, 0, 0);
      drain();
   endtask

   task automatic finish_run();
      @(negedge bclk); ws = 1'b1; sd = 1'b0;
      repeat (6) @(negedge bclk);
      drain();
      chk(exp_q.size() == 0, "R1 every frame produced a word", 32'(exp_q.size()), 32'd0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      #(10 * 150000);
      nchk++; nfail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      t_reset();
      t_wide();
      t_narrow();
      t_mode_switch();
      t_extremes();
      finish_run();
   end

endmodule